// File: doc/BRIEF.md
# NAND Page ECC Engine

This block sits beside a NAND flash bus and listens to it. It recognises a page read command (0x00) or a page program command (0x80), waits for the five address cycles that follow, and then counts the data words that pass. Over the main data area of the page it builds a 32-bit single-error-correct, double-error-detect code. The code is made of a 16-bit parity word and a 16-bit inverse-parity word. When the word count reaches the full page size, which includes the spare area, the code is marked valid and stays frozen until the next start sequence.

After a program, software reads the parity and inverse-parity outputs and stores them in the spare area itself. After a read, software fetches the stored code from the spare area and writes it into the block. The block forms the syndrome and sorts it into one of four classes:

- no error;
- a correctable single-bit error, reported with the word offset and the bit index;
- an error inside the stored code;
- multiple errors.

Correcting the data is left to software.

Top module: `nand_ecc`

## Requirements
- R1: After reset, parity_o, nparity_o, valid_o, done_o, rec_err_o, ecc_err_o, mul_err_o, word_addr_o and bit_addr_o are all zero.
- R2: A command cycle is a cycle with stb_i=1 and cle_i=1, and the command value is data_i[7:0].
  - A command cycle carrying 0x00 or 0x80 starts a page. It clears parity_o, nparity_o, valid_o, done_o and all three error flags, and it latches page_sel_i and bus16_i.
  - A command cycle carrying any other value has no effect.
- R3: After a start, the five address cycles (stb_i=1, ale_i=1, cle_i=0) must all arrive before data counting begins. A data strobe (stb_i=1, cle_i=0, ale_i=0) that arrives before the fifth address cycle is ignored.
- R4: page_sel_i selects the page size. The values 0, 1, 2 and 3 select 528, 1056, 2112 and 4224 words. Of these, 512, 1024, 2048 and 4096 words are main data. valid_o rises in the cycle after the last data strobe of the page, and not earlier.
- R5: The address of a main-data bit is formed as follows.
  - The bit address is A = word_index*16 + bit when bus16_i=1, or A = word_index*8 + bit when bus16_i=0. Only data_i[7:0] is used in 8-bit mode.
  - With n = (bus16_i ? 4 : 3) + 9 + page_sel_i, bit k < n of parity_o is the XOR of all main-data bits whose A has bit k set.
  - Bit k of nparity_o is the XOR of the main-data bits whose A has bit k clear.
  - Bits n and above of both outputs are zero. Spare-area words do not enter either output.
- R6: Once valid_o is high, data strobes and address cycles leave parity_o and nparity_o unchanged until the next start or clear.
- R7: A write with code_we_i=1 supplies the stored code. code_i[15:0] is the stored parity and code_i[31:16] is the stored inverse parity.
  - The write is accepted only while valid_o=1. done_o and the classification then appear in the next cycle.
  - A write while valid_o=0 is ignored.
- R8: If both syndromes are zero over the used n bits, done_o rises with rec_err_o, ecc_err_o and mul_err_o all zero. The parity syndrome is stored parity XOR parity_o, and the inverse syndrome is stored inverse parity XOR nparity_o.
- R9: If every used bit pair of the two syndromes differs, only rec_err_o is set.
  - bit_addr_o takes the low 4 bits (16-bit mode) or the low 3 bits (8-bit mode) of the parity syndrome.
  - word_addr_o takes the parity syndrome bits above those.
- R10: If exactly one bit of the two syndromes together is set, only ecc_err_o is set.
- R11: Any other nonzero syndrome sets only mul_err_o.
- R12: A one-cycle pulse on clr_i clears parity_o, nparity_o, valid_o, done_o and the error flags, and it abandons the page in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| page_sel_i | input | 2 | Page size select, latched at start |
| bus16_i | input | 1 | 1 = 16-bit data words, 0 = 8-bit, latched at start |
| cle_i | input | 1 | Snooped command latch qualifier |
| ale_i | input | 1 | Snooped address latch qualifier |
| stb_i | input | 1 | One-cycle bus transfer strobe |
| data_i | input | 16 | Snooped bus data |
| clr_i | input | 1 | Software clear strobe |
| code_we_i | input | 1 | Stored code write strobe |
| code_i | input | 32 | Stored code {inverse parity, parity} |
| parity_o | output | 16 | Computed parity word |
| nparity_o | output | 16 | Computed inverse-parity word |
| valid_o | output | 1 | Page complete, code frozen |
| done_o | output | 1 | Classification valid |
| rec_err_o | output | 1 | Correctable single-bit error |
| ecc_err_o | output | 1 | Error inside the stored code |
| mul_err_o | output | 1 | Multiple errors |
| word_addr_o | output | 12 | Word offset of the correctable error |
| bit_addr_o | output | 4 | Bit index of the correctable error |

## Verification
The bench flips single bits at the largest word offset of the biggest page and at an upper bit of a 16-bit word. A design that misplaced the word index in the bit address, or that masked the used width wrongly, would report the wrong location or a multiple error. It places stray data strobes between the fourth and fifth address cycles, and it feeds extra strobes and a foreign command after page end. A sequencer that counted too early would corrupt the code, and one that did not freeze would change the code after valid_o. A single flipped stored-code bit and a double data error separate the stored-code class from the multiple-error class, which a classifier that only counted syndrome bits would confuse. A stored-code write before valid_o must leave done_o low.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_DATA, SQ_LOCK} seq_state_e;

  // number of used code bits for the latched mode
  function automatic int code_bits(input logic b16, input logic [1:0] sel,
                                   input int bit_w, input int min_log2);
    return (b16 ? bit_w : bit_w - 1) + min_log2 + int'(sel);
  endfunction
endpackage

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter int CMD_W         = 8,
  parameter logic [CMD_W-1:0] CMD_RD = 8'h00,
  parameter logic [CMD_W-1:0] CMD_PG = 8'h80,
  parameter int ADDR_CYC      = 5,
  parameter int MAIN_LOG2_MIN = 9,
  parameter int SEL_W         = 2,
  parameter int SPARE_SHIFT   = 5,
  localparam int MAX_LOG2     = MAIN_LOG2_MIN + (1 << SEL_W) - 1,
  localparam int WADDR_W      = MAX_LOG2,
  localparam int CNT_W        = MAX_LOG2 + 1,
  localparam int ACNT_W       = $clog2(ADDR_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   page_sel_i,
  input  logic               bus16_i,
  input  logic               cle_i,
  input  logic               ale_i,
  input  logic               stb_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               clr_i,
  output logic               start_o,
  output logic               acc_en_o,
  output logic [WADDR_W-1:0] word_idx_o,
  output logic [SEL_W-1:0]   sel_q_o,
  output logic               b16_q_o,
  output logic               vld_o
);
  seq_state_e        state_q;
  logic [ACNT_W-1:0] acnt_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic [CNT_W-1:0]  main_words, page_words;
  logic              addr_stb, data_stb;

  assign start_o  = stb_i & cle_i & ((cmd_i == CMD_RD) | (cmd_i == CMD_PG));
  assign addr_stb = stb_i & ale_i & ~cle_i;
  assign data_stb = stb_i & ~ale_i & ~cle_i;

  assign main_words = CNT_W'(1) << (MAIN_LOG2_MIN + int'(sel_q_o));
  assign page_words = main_words + (main_words >> SPARE_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      acnt_q  <= '0;
      wcnt_q  <= '0;
      vld_o   <= 1'b0;
      sel_q_o <= '0;
      b16_q_o <= 1'b0;
    end else if (clr_i) begin
      state_q <= SQ_IDLE;
      acnt_q  <= '0;
      wcnt_q  <= '0;
      vld_o   <= 1'b0;
    end else if (start_o) begin
      state_q <= SQ_ADDR;
      acnt_q  <= '0;
      wcnt_q  <= '0;
      vld_o   <= 1'b0;
      sel_q_o <= page_sel_i;
      b16_q_o <= bus16_i;
    end else begin
      unique case (state_q)
        SQ_ADDR: if (addr_stb) begin
          if (acnt_q == ACNT_W'(ADDR_CYC - 1)) begin
            state_q <= SQ_DATA;
            acnt_q  <= '0;
          end else begin
            acnt_q <= acnt_q + 1'b1;
          end
        end
        SQ_DATA: if (data_stb) begin
          if (wcnt_q == page_words - CNT_W'(1)) begin
            state_q <= SQ_LOCK;
            vld_o   <= 1'b1;
          end
          wcnt_q <= wcnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign acc_en_o   = (state_q == SQ_DATA) & data_stb & ~clr_i & (wcnt_q < main_words);
  assign word_idx_o = wcnt_q[WADDR_W-1:0];

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_DATA) |-> (wcnt_q < page_words));
  assert_vld_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> $past(data_stb));
  assert_no_early_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_ADDR) |-> !acc_en_o);
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int WADDR_W       = 12,
  parameter int MAIN_LOG2_MIN = 9,
  parameter int SEL_W         = 2,
  localparam int BIT_W        = $clog2(DATA_W),
  localparam int CODE_W       = WADDR_W + BIT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic               b16_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [WADDR_W-1:0] word_idx_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [CODE_W-1:0]  par_o,
  output logic [CODE_W-1:0]  npar_o
);
  logic [CODE_W-1:0] used, p_nxt, np_nxt;

  always_comb begin
    for (int k = 0; k < CODE_W; k++)
      used[k] = (k < code_bits(b16_i, 2'(sel_i), BIT_W, MAIN_LOG2_MIN));
  end

  always_comb begin
    logic [CODE_W-1:0] addr;
    logic [BIT_W-1:0]  bidx;
    p_nxt  = par_o;
    np_nxt = npar_o;
    for (int b = 0; b < DATA_W; b++) begin
      bidx = BIT_W'(b);
      addr = b16_i ? {word_idx_i, bidx} : {1'b0, word_idx_i, bidx[BIT_W-2:0]};
      if (b16_i || (b < DATA_W / 2)) begin
        for (int k = 0; k < CODE_W; k++) begin
          if (used[k]) begin
            if (addr[k]) p_nxt[k]  = p_nxt[k]  ^ data_i[b];
            else         np_nxt[k] = np_nxt[k] ^ data_i[b];
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_o  <= '0;
      npar_o <= '0;
    end else if (clr_i) begin
      par_o  <= '0;
      npar_o <= '0;
    end else if (en_i) begin
      par_o  <= p_nxt;
      npar_o <= np_nxt;
    end
  end

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (par_o == '0 && npar_o == '0));
  assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> (((par_o | npar_o) & ~$past(used)) == '0));
endmodule

// File: rtl/nand_ecc_class.sv
module nand_ecc_class
  import nand_ecc_pkg::*;
#(
  parameter int WADDR_W       = 12,
  parameter int BIT_W         = 4,
  parameter int MAIN_LOG2_MIN = 9,
  parameter int SEL_W         = 2,
  localparam int CODE_W       = WADDR_W + BIT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                we_i,
  input  logic                vld_i,
  input  logic [2*CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0]   par_i,
  input  logic [CODE_W-1:0]   npar_i,
  input  logic                b16_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                done_o,
  output logic                rec_o,
  output logic                ecc_o,
  output logic                mul_o,
  output logic [WADDR_W-1:0]  word_addr_o,
  output logic [BIT_W-1:0]    bit_addr_o
);
  logic [CODE_W-1:0] used, sp, snp;
  logic              s_zero, s_corr, s_one;

  always_comb begin
    for (int k = 0; k < CODE_W; k++)
      used[k] = (k < code_bits(b16_i, 2'(sel_i), BIT_W, MAIN_LOG2_MIN));
  end

  assign sp     = (par_i  ^ code_i[CODE_W-1:0])      & used;
  assign snp    = (npar_i ^ code_i[2*CODE_W-1:CODE_W]) & used;
  assign s_zero = ({sp, snp} == '0);
  assign s_corr = ((sp ^ snp) == used);
  assign s_one  = ($countones({sp, snp}) == 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      rec_o       <= 1'b0;
      ecc_o       <= 1'b0;
      mul_o       <= 1'b0;
      word_addr_o <= '0;
      bit_addr_o  <= '0;
    end else if (clr_i) begin
      done_o      <= 1'b0;
      rec_o       <= 1'b0;
      ecc_o       <= 1'b0;
      mul_o       <= 1'b0;
      word_addr_o <= '0;
      bit_addr_o  <= '0;
    end else if (we_i && vld_i) begin
      done_o <= 1'b1;
      rec_o  <= s_corr;
      ecc_o  <= s_one;
      mul_o  <= !s_zero && !s_corr && !s_one;
      if (s_corr) begin
        bit_addr_o  <= b16_i ? sp[BIT_W-1:0] : {1'b0, sp[BIT_W-2:0]};
        word_addr_o <= b16_i ? sp[CODE_W-1:BIT_W] : sp[CODE_W-2:BIT_W-1];
      end else begin
        bit_addr_o  <= '0;
        word_addr_o <= '0;
      end
    end
  end

  assert_flag_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rec_o, ecc_o, mul_o}));
  assert_done_needs_vld_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> vld_i);
  assert_ignore_early_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !vld_i && !clr_i) |=> $stable(done_o));
  assert_flags_need_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(rec_o || ecc_o || mul_o));
endmodule

// File: rtl/nand_ecc.sv
module nand_ecc
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_CYC      = 5,
  parameter int MAIN_LOG2_MIN = 9,
  parameter int SEL_W         = 2,
  parameter int SPARE_SHIFT   = 5,
  localparam int BIT_W        = $clog2(DATA_W),
  localparam int WADDR_W      = MAIN_LOG2_MIN + (1 << SEL_W) - 1,
  localparam int CODE_W       = WADDR_W + BIT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    page_sel_i,
  input  logic                bus16_i,
  input  logic                cle_i,
  input  logic                ale_i,
  input  logic                stb_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                clr_i,
  input  logic                code_we_i,
  input  logic [2*CODE_W-1:0] code_i,
  output logic [CODE_W-1:0]   parity_o,
  output logic [CODE_W-1:0]   nparity_o,
  output logic                valid_o,
  output logic                done_o,
  output logic                rec_err_o,
  output logic                ecc_err_o,
  output logic                mul_err_o,
  output logic [WADDR_W-1:0]  word_addr_o,
  output logic [BIT_W-1:0]    bit_addr_o
);
  logic               start, acc_en, b16_q, clr_all;
  logic [WADDR_W-1:0] word_idx;
  logic [SEL_W-1:0]   sel_q;

  assign clr_all = start | clr_i;

  nand_ecc_seq #(
    .CMD_W(8), .CMD_RD(8'h00), .CMD_PG(8'h80), .ADDR_CYC(ADDR_CYC),
    .MAIN_LOG2_MIN(MAIN_LOG2_MIN), .SEL_W(SEL_W), .SPARE_SHIFT(SPARE_SHIFT)
  ) i_seq (
    .clk_i, .rst_ni, .page_sel_i, .bus16_i, .cle_i, .ale_i, .stb_i,
    .cmd_i(data_i[7:0]), .clr_i, .start_o(start), .acc_en_o(acc_en),
    .word_idx_o(word_idx), .sel_q_o(sel_q), .b16_q_o(b16_q), .vld_o(valid_o)
  );

  nand_ecc_accum #(
    .DATA_W(DATA_W), .WADDR_W(WADDR_W), .MAIN_LOG2_MIN(MAIN_LOG2_MIN), .SEL_W(SEL_W)
  ) i_accum (
    .clk_i, .rst_ni, .clr_i(clr_all), .en_i(acc_en), .b16_i(b16_q), .sel_i(sel_q),
    .word_idx_i(word_idx), .data_i, .par_o(parity_o), .npar_o(nparity_o)
  );

  nand_ecc_class #(
    .WADDR_W(WADDR_W), .BIT_W(BIT_W), .MAIN_LOG2_MIN(MAIN_LOG2_MIN), .SEL_W(SEL_W)
  ) i_class (
    .clk_i, .rst_ni, .clr_i(clr_all), .we_i(code_we_i), .vld_i(valid_o), .code_i,
    .par_i(parity_o), .npar_i(nparity_o), .b16_i(b16_q), .sel_i(sel_q),
    .done_o, .rec_o(rec_err_o), .ecc_o(ecc_err_o), .mul_o(mul_err_o),
    .word_addr_o, .bit_addr_o
  );

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !clr_i && !start) |=> ($stable(parity_o) && $stable(nparity_o)));
  assert_sw_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!valid_o && !done_o));
endmodule

// File: tb/test_nand_ecc.sv
module test_nand_ecc;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  page_sel_i = '0;
  logic        bus16_i = 1'b0;
  logic        cle_i = 1'b0, ale_i = 1'b0, stb_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        clr_i = 1'b0, code_we_i = 1'b0;
  logic [31:0] code_i = '0;
  logic [15:0] parity_o, nparity_o;
  logic        valid_o, done_o, rec_err_o, ecc_err_o, mul_err_o;
  logic [11:0] word_addr_o;
  logic [3:0]  bit_addr_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [15:0] mem [4096];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  nand_ecc i_nand_ecc (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int sel, input bit b16);
    logic [15:0] p = '0, np = '0;
    int n = (b16 ? 4 : 3) + 9 + sel;
    int width = b16 ? 16 : 8;
    for (int w = 0; w < (512 << sel); w++)
      for (int b = 0; b < width; b++) begin
        int a = b16 ? w * 16 + b : w * 8 + b;
        for (int k = 0; k < n; k++)
          if ((a >> k) & 1) p[k] = p[k] ^ mem[w][b];
          else              np[k] = np[k] ^ mem[w][b];
      end
    return {np, p};
  endfunction

  task automatic fill(input int sel, input bit b16, input int seed);
    for (int w = 0; w < (512 << sel); w++) begin
      mem[w] = 16'((w * 40503) ^ (w >> 3) ^ seed);
      if (!b16) mem[w][15:8] = '0;
    end
  endtask

  task automatic pulse(input bit c, input bit a, input logic [15:0] d);
    cle_i = c; ale_i = a; data_i = d; stb_i = 1'b1;
    @(negedge clk_i);
    stb_i = 1'b0; cle_i = 1'b0; ale_i = 1'b0;
  endtask

  task automatic start_page(input logic [7:0] cmd, input int sel, input bit b16);
    page_sel_i = 2'(sel); bus16_i = b16;
    pulse(1'b1, 1'b0, {8'h00, cmd});
    for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1, 16'(i));
  endtask

  task automatic send_page(input int sel);
    int main_n = 512 << sel;
    int page_n = main_n + (main_n >> 5);
    for (int w = 0; w < page_n; w++) begin
      if (w == page_n - 1) check("R4 valid low before last word", 32'(valid_o), 0);
      pulse(1'b0, 1'b0, (w < main_n) ? mem[w] : 16'hFFFF);
    end
    check("R4 valid after last word", 32'(valid_o), 1);
  endtask

  task automatic write_code(input logic [31:0] c);
    code_i = c; code_we_i = 1'b1;
    @(negedge clk_i);
    code_we_i = 1'b0;
  endtask

  task automatic expect_status(input string tag, input bit rec, input bit ecc, input bit mul,
                               input int wa, input int ba);
    check({tag, " done"}, 32'(done_o), 1);
    check({tag, " flags"}, {29'd0, rec_err_o, ecc_err_o, mul_err_o}, {29'd0, rec, ecc, mul});
    check({tag, " word"}, 32'(word_addr_o), 32'(wa));
    check({tag, " bit"}, 32'(bit_addr_o), 32'(ba));
  endtask

  task automatic t_reset;
    check("R1 parity", {nparity_o, parity_o}, 0);
    check("R1 status", {26'd0, valid_o, done_o, rec_err_o, ecc_err_o, mul_err_o, 1'b0}, 0);
    check("R1 addr", {16'd0, word_addr_o, bit_addr_o}, 0);
  endtask

  task automatic t_write_clean;
    logic [31:0] c;
    fill(0, 1'b0, 16'h5a);
    start_page(8'h80, 0, 1'b0);
    send_page(0);
    c = model(0, 1'b0);
    check("R5 code 8-bit 528", {nparity_o, parity_o}, c);
    write_code(c);
    expect_status("R8 clean", 1'b0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_lock;
    logic [31:0] c = {nparity_o, parity_o};
    for (int i = 0; i < 5; i++) pulse(1'b0, 1'b0, 16'h00F3 + 16'(i));
    pulse(1'b0, 1'b1, 16'h0011);
    check("R6 frozen after page", {nparity_o, parity_o}, c);
    pulse(1'b1, 1'b0, 16'h0090);
    pulse(1'b0, 1'b0, 16'h00AA);
    check("R2 other command ignored code", {nparity_o, parity_o}, c);
    check("R2 other command ignored valid", {30'd0, valid_o, done_o}, 32'd3);
  endtask

  task automatic t_clear;
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    check("R12 clear code", {nparity_o, parity_o}, 0);
    check("R12 clear status", {27'd0, valid_o, done_o, rec_err_o, ecc_err_o, mul_err_o}, 0);
    pulse(1'b1, 1'b0, 16'h0070);
    for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1, 16'h0);
    for (int i = 0; i < 8; i++) pulse(1'b0, 1'b0, 16'h00FF);
    check("R2 non-start command no count", {15'd0, valid_o, parity_o | nparity_o}, 0);
  endtask

  task automatic t_single(input int sel, input bit b16, input int wa, input int ba, input int seed);
    logic [31:0] c;
    fill(sel, b16, seed);
    c = model(sel, b16);
    mem[wa][ba] = ~mem[wa][ba];
    start_page(8'h00, sel, b16);
    send_page(sel);
    check("R7 done low before code", 32'(done_o), 0);
    write_code(c);
    expect_status("R9 single", 1'b1, 1'b0, 1'b0, wa, ba);
  endtask

  task automatic t_ecc;
    logic [31:0] c;
    fill(2, 1'b1, 16'h77);
    c = model(2, 1'b1);
    start_page(8'h00, 2, 1'b1);
    check("R2 start clears done", {29'd0, done_o, rec_err_o, valid_o}, 0);
    send_page(2);
    write_code(c ^ 32'h0020_0000);
    expect_status("R10 stored code bit", 1'b0, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_mul;
    logic [31:0] c;
    fill(0, 1'b1, 16'h1234);
    c = model(0, 1'b1);
    mem[10][3] = ~mem[10][3];
    mem[200][12] = ~mem[200][12];
    start_page(8'h00, 0, 1'b1);
    send_page(0);
    write_code(c);
    expect_status("R11 double", 1'b0, 1'b0, 1'b1, 0, 0);
  endtask

  task automatic t_addr_gate;
    logic [31:0] c;
    fill(1, 1'b0, 16'h3c);
    c = model(1, 1'b0);
    page_sel_i = 2'd1; bus16_i = 1'b0;
    pulse(1'b1, 1'b0, 16'h0000);
    for (int i = 0; i < 4; i++) pulse(1'b0, 1'b1, 16'h0);
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b0, 16'h00C7);
    write_code(32'h0);
    check("R7 code write before valid ignored", 32'(done_o), 0);
    pulse(1'b0, 1'b1, 16'h0);
    send_page(1);
    check("R3 early data ignored", {nparity_o, parity_o}, c);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_write_clean();
    t_lock();
    t_clear();
    t_single(1, 1'b1, 1000, 13, 16'h0abc);
    t_single(3, 1'b0, 4095, 7, 16'h00e1);
    t_ecc();
    t_mul();
    t_addr_gate();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule